// File: doc/BRIEF.md
# Vectorized Key Membership Search

The block answers one question: does a 32-bit key occur among the first N elements of a candidate array held in a local memory? After a start handshake delivers the key, the base address of the array and the element count N, the block copies the key into all four lanes of a 128-bit vector. It then fetches the array one vector at a time from a synchronous read port. Each fetched vector is compared lane by lane against the broadcast key, and the four lane results are OR-reduced to a single hit bit.

Reads go out one per cycle, ahead of the compare results. The memory answers a fixed three cycles after a read is issued, and compare and reduce take one registered cycle each. A search that finds nothing therefore occupies ceil(N/4)+5 cycles. A hit ends the search at the vector that produced it. Reads still in flight at that point are dropped, so a following search never sees their data. Lanes beyond the element count in the last vector are masked and never match. The result is the first matching element index.

Top module: `vec_key_search`

## Requirements
- R1: After reset, done and found are low, index is zero, ready is high and rd_en is low.
- R2: A search reports found=1 when the key equals any element among the first N, with index equal to that element's position relative to the base. Element e sits in vector base+e/4, in lane e%4, and lane L occupies rd_data bits [32L+31:32L].
- R3: When several elements match, index reports the lowest matching position, both within one vector and across vectors.
- R4: When no element matches, done is first high ceil(N/4)+5 cycles after the cycle in which start was accepted, with found=0 and index=0.
- R5: When the first match lies in vector k (counted from the base), done is first high k+6 cycles after the accepting cycle.
- R6: Lanes whose element position is N or higher never produce a match.
- R7: A start with N=0 gives done=1 and found=0 in the next cycle, and issues no read.
- R8: Reads go out on consecutive cycles to consecutive vector addresses starting at base. Exactly min(ceil(N/4), k+5) reads are issued, where k is the hit vector (or ceil(N/4)-1 on a miss). No read is issued while done is high.
- R9: ready is low from the cycle after acceptance until done, and a start raised during that time is ignored.
- R10: done is high for a single cycle, and found and index hold their values until the next accepted start.
- R11: Read data still in flight when a hit ends a search has no effect on a search accepted in the cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search; accepted when ready is high |
| ready | output | 1 | Block is idle and will accept start |
| key | input | 32 | Value to look for |
| base | input | 16 | Vector address of element 0 |
| count | input | 16 | Number of candidate elements N |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | 16 | Vector address of the read |
| rd_data | input | 128 | Four 32-bit lanes, returned three cycles after the request |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | The key was found in the last search |
| index | output | 16 | Lowest matching element position |

## Verification
Every search result is checked in exactly the cycle it is due. The bench counts clock edges from the edge that accepts start and requires done to be first seen after edge ceil(N/4)+5 on a miss, or edge k+6 on a hit in vector k. For N=0 the expected edge is the next one. All sampling happens one time unit after the edge. found, index and the number and addresses of the reads are compared at the done cycle, and again one cycle later to confirm that they hold. The stale-data case starts a new search in the very cycle that done is high, so that old reads still arrive during the new search's first cycles.

// File: rtl/vec_key_search.sv
module vec_key_search #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 4,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int MEM_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    ready,
  input  logic [LANE_W-1:0]       key,
  input  logic [ADDR_W-1:0]       base,
  input  logic [CNT_W-1:0]        count,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] rd_data,
  output logic                    done,
  output logic                    found,
  output logic [CNT_W-1:0]        index
);
  localparam int LSH = $clog2(LANES);
  localparam int EW  = CNT_W + LSH;

  logic              busy;
  logic [CNT_W:0]    left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  vec_q, n_q;
  logic [LANE_W-1:0] key_q;

  logic [MEM_LAT-1:0] tv, tlast;
  logic [CNT_W-1:0]   tvec [MEM_LAT];

  logic              cmp_v, cmp_last;
  logic [CNT_W-1:0]  cmp_vec;
  logic [LANES-1:0]  eq_q, lane_eq;
  logic [LSH-1:0]    first;

  logic              done_q, found_q;
  logic [CNT_W-1:0]  index_q;

  wire accept = start && !busy;
  wire hit    = |eq_q;
  wire finish = busy && cmp_v && (hit || cmp_last);
  wire [CNT_W:0] vecs = ({1'b0, count} + (CNT_W+1)'(LANES - 1)) >> LSH;

  assign ready   = !busy;
  assign rd_en   = busy && (left_q != '0);
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign found   = found_q;
  assign index   = index_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire [EW-1:0] elem = {tvec[MEM_LAT-1], LSH'(l)};
    assign lane_eq[l] = (rd_data[l*LANE_W +: LANE_W] == key_q) &&
                        (elem < {{LSH{1'b0}}, n_q});
  end

  always_comb begin
    first = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (eq_q[l]) first = LSH'(l);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; left_q <= '0; addr_q <= '0; vec_q <= '0; n_q <= '0; key_q <= '0;
      tv <= '0; tlast <= '0;
      for (int i = 0; i < MEM_LAT; i++) tvec[i] <= '0;
      cmp_v <= 1'b0; cmp_last <= 1'b0; cmp_vec <= '0; eq_q <= '0;
      done_q <= 1'b0; found_q <= 1'b0; index_q <= '0;
    end else begin
      done_q   <= 1'b0;
      tv[0]    <= rd_en;
      tlast[0] <= (left_q == (CNT_W+1)'(1));
      tvec[0]  <= vec_q;
      for (int i = 1; i < MEM_LAT; i++) begin
        tv[i]    <= tv[i-1];
        tlast[i] <= tlast[i-1];
        tvec[i]  <= tvec[i-1];
      end
      cmp_v    <= tv[MEM_LAT-1];
      cmp_last <= tlast[MEM_LAT-1];
      cmp_vec  <= tvec[MEM_LAT-1];
      eq_q     <= lane_eq;
      if (rd_en) begin
        addr_q <= addr_q + 1'b1;
        vec_q  <= vec_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (accept) begin
        key_q   <= key;
        n_q     <= count;
        addr_q  <= base;
        vec_q   <= '0;
        left_q  <= vecs;
        found_q <= 1'b0;
        index_q <= '0;
        if (count == '0) done_q <= 1'b1;
        else             busy   <= 1'b1;
      end else if (finish) begin
        done_q  <= 1'b1;
        busy    <= 1'b0;
        found_q <= hit;
        index_q <= hit ? CNT_W'({cmp_vec, first}) : '0;
        left_q  <= '0;
        tv      <= '0;
        cmp_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_key_search_chk.sv
module vec_key_search_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic [CNT_W-1:0]  count,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              found
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(start && ready && count == '0) |=> !done);
  // R10
  found_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> done);
  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready && count == '0 |=> done && !found);
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);
  // R8
  done_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);
  // R9
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !ready);
endmodule

bind vec_key_search vec_key_search_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .count(count),
  .rd_en(rd_en), .rd_addr(rd_addr), .done(done), .found(found));

// File: tb/vec_key_search_test.sv
module vec_key_search_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [31:0] key;
    logic [15:0] base;
    logic [15:0] n;
    logic        f;
    logic [15:0] idx;
    logic [7:0]  cyc;
    logic [7:0]  reads;
  } vec_t;

  // R2 R3 R4 R5 R6 R8 cases: key, base, N, found, index, cycles, reads
  localparam vec_t TBL [11] = '{
    '{32'h1000_0001, 16'd0,  16'd12, 1'b1, 16'd1,  8'd6,  8'd3},
    '{32'h1000_0017, 16'd2,  16'd16, 1'b1, 16'd15, 8'd9,  8'd4},
    '{32'hDEAD_0000, 16'd4,  16'd8,  1'b0, 16'd0,  8'd7,  8'd2},
    '{32'h1000_0016, 16'd4,  16'd6,  1'b0, 16'd0,  8'd7,  8'd2},
    '{32'h1000_0016, 16'd4,  16'd7,  1'b1, 16'd6,  8'd7,  8'd2},
    '{32'h1000_0020, 16'd8,  16'd1,  1'b1, 16'd0,  8'd6,  8'd1},
    '{32'h1000_0021, 16'd8,  16'd1,  1'b0, 16'd0,  8'd6,  8'd1},
    '{32'hDEAD_0000, 16'd10, 16'd37, 1'b0, 16'd0,  8'd15, 8'd10},
    '{32'hABCD_0001, 16'd20, 16'd8,  1'b1, 16'd1,  8'd6,  8'd2},
    '{32'h5555_0000, 16'd30, 16'd8,  1'b1, 16'd2,  8'd6,  8'd2},
    '{32'h1000_0039, 16'd10, 16'd37, 1'b1, 16'd17, 8'd10, 8'd9}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] key = 0;
  logic [15:0] base = 0, count = 0;
  logic ready, rd_en, done, found;
  logic [15:0] rd_addr, index;
  logic [127:0] rd_data, p1, p2;
  logic [127:0] mem [64];

  int checks = 0, fails = 0, rd_cnt = 0, addr_err = 0, cyc = 0;
  logic [15:0] base_cur = 0;

  always #(PERIOD/2) clk = ~clk;

  vec_key_search uut (.clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .key(key),
    .base(base), .count(count), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .found(found), .index(index));

  always @(posedge clk) begin
    p1 <= rd_en ? mem[rd_addr[5:0]] : '0;
    p2 <= p1;
    rd_data <= p2;
    if (rd_en) begin
      if (rd_addr != base_cur + 16'(rd_cnt)) addr_err++;
      rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] k, input logic [15:0] b, input logic [15:0] n);
    key = k; base = b; count = n; start = 1; base_cur = b; rd_cnt = 0; addr_err = 0;
    @(posedge clk); #1; cyc = 1;
    check(ready == 0, "R9 ready low", ready, 0);
    key = 32'h1000_0003; base = 16'd60; count = 16'd5;
    @(posedge clk); #1; cyc = 2;
    start = 0;
    while (!done && cyc < 200) begin @(posedge clk); #1; cyc++; end
  endtask

  task automatic verify(input vec_t t, input string tag);
    check(cyc == int'(t.cyc), {tag, " R4/R5 done cycle"}, cyc, int'(t.cyc));
    check(found == t.f, {tag, " R2/R6 found"}, found, t.f);
    check(index == t.idx, {tag, " R2/R3 index"}, index, t.idx);
    check(rd_cnt == int'(t.reads) && addr_err == 0, {tag, " R8 reads"}, rd_cnt, int'(t.reads));
  endtask

  task automatic hold_check(input vec_t t);
    @(posedge clk); #1;
    check(done == 0, "R10 done pulse", done, 0);
    check(found == t.f && index == t.idx, "R10 result held", index, t.idx);
  endtask

  initial begin
    for (int a = 0; a < 64; a++)
      for (int l = 0; l < 4; l++)
        mem[a][l*32 +: 32] = 32'h1000_0000 + 32'(a*4 + l);
    mem[20][63:32] = 32'hABCD_0001; mem[20][127:96] = 32'hABCD_0001;
    mem[21][31:0]  = 32'hABCD_0001;
    mem[30][95:64] = 32'h5555_0000; mem[31][31:0] = 32'h5555_0000;

    repeat (3) @(posedge clk);
    #1;
    // R1
    check(done == 0 && found == 0 && index == 0, "R1 outputs", index, 0);
    check(ready == 1 && rd_en == 0, "R1 ready/rd_en", ready, 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      launch(TBL[i].key, TBL[i].base, TBL[i].n);
      verify(TBL[i], $sformatf("row%0d", i));
      hold_check(TBL[i]);
      @(negedge clk);
    end

    // R11: start a new search in the done cycle of a hit while old reads are in flight
    launch(32'h1000_0000, 16'd0, 16'd12);
    verify('{32'h1000_0000, 16'd0, 16'd12, 1'b1, 16'd0, 8'd6, 8'd3}, "R11 first");
    launch(32'h1000_0004, 16'd40, 16'd4);
    verify('{32'h1000_0004, 16'd40, 16'd4, 1'b0, 16'd0, 8'd6, 8'd1}, "R11 second");
    @(negedge clk);
    launch(32'h1000_00A2, 16'd40, 16'd4);
    verify('{32'h1000_00A2, 16'd40, 16'd4, 1'b1, 16'd2, 8'd6, 8'd1}, "R11 third");
    @(negedge clk);

    // R7: zero count
    key = 32'h1000_0000; base = 0; count = 0; start = 1; rd_cnt = 0;
    @(posedge clk); #1; start = 0;
    check(done == 1 && found == 0, "R7 immediate done", done, 1);
    check(ready == 1, "R7 stays ready", ready, 1);
    @(posedge clk); #1;
    check(rd_cnt == 0 && done == 0, "R7 no read", rd_cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule